// File: doc/BRIEF.md
# Decode-Stage Hazard Controller (Load-Use Interlock and Branch Redirect)

This block holds the hazard decisions for the decode stage of a five-stage in-order pipeline. It has two jobs. The first is a load-use interlock. When the instruction now in decode reads a register that the load one stage ahead has not yet produced, the block freezes the program counter and the fetch/decode register for one cycle. It also replaces the control word going into the execute stage with all zeros, so that a bubble travels down the pipeline in place of the dependent instruction.

The second job is to resolve conditional branches early, in decode. The block compares the two operand values read from the register file. It forms the target as the sequential address plus the sign-extended immediate scaled to word size. On a taken branch it selects the target as the next fetch address and squashes the single wrong-path instruction that was fetched behind the branch. Fetch always continues sequentially until a branch resolves taken, so a taken branch costs one slot.

The block is purely combinational. The surrounding pipeline owns every register. The datapath that forwards values to the decode comparator is not part of this block.

Top module: `hzd_decode_ctrl`

## Requirements
- R1: A stall is raised exactly when `idex_mem_read` is 1 and `idex_rt` equals `ifid_rs` or `ifid_rt`. Register index 0 is not exempt.
- R2: While stalled, `ctrl_zero_sel` is 1 and `ctrl_out` is all zeros. Otherwise `ctrl_zero_sel` is 0 and `ctrl_out` equals `ctrl_in`.
- R3: While stalled, `pc_write_en` and `ifid_write_en` are both 0. Otherwise both are 1.
- R4: `branch_target` always equals `ifid_pc_plus4` plus the sign-extended `ifid_imm` shifted left by 2, modulo 2^XLEN. This covers negative offsets and wrap-around.
- R5: When `ifid_is_branch` is 1, `rd_data_a` equals `rd_data_b` and there is no stall, both `pc_redirect` and `ifid_flush` are 1.
- R6: When the branch is not taken, because the operands differ or the instruction is not a branch, `pc_redirect` and `ifid_flush` are both 0, and the next fetch address is sequential.
- R7: A stall takes priority over branch resolution. A branch that would be taken raises neither `pc_redirect` nor `ifid_flush` while stalled, and resolves in the cycle after the stall clears.
- R8: In a pipeline built around the block, a load followed directly by a dependent instruction puts exactly one zero control word into the execute stage. The PC and the fetch/decode register hold for that one cycle. A load followed by an independent instruction inserts none.
- R9: In a pipeline built around the block, a taken branch squashes exactly one instruction. The fetch/decode register is loaded with an all-zero word, and fetch continues at the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_mem_read | input | 1 | Instruction in the execute stage is a load |
| idex_rt | input | RAW | Destination register of that load |
| ifid_rs | input | RAW | First source register of the decode instruction |
| ifid_rt | input | RAW | Second source register of the decode instruction |
| ifid_is_branch | input | 1 | Decode instruction is a branch-if-equal |
| ifid_pc_plus4 | input | XLEN | Sequential address that travels with the decode instruction |
| ifid_imm | input | IMM_W | Signed word offset of the branch |
| rd_data_a | input | XLEN | Register value for the first source |
| rd_data_b | input | XLEN | Register value for the second source |
| ctrl_in | input | CTRL_W | Control word produced by the decoder |
| pc_write_en | output | 1 | PC register load enable |
| ifid_write_en | output | 1 | Fetch/decode register load enable |
| ctrl_zero_sel | output | 1 | Selects the all-zero control word |
| ctrl_out | output | CTRL_W | Control word to write into the execute-stage register |
| ifid_flush | output | 1 | Clears the fetch/decode register to an all-zero word |
| pc_redirect | output | 1 | Next PC is `branch_target`, not the sequential address |
| branch_target | output | XLEN | Computed branch destination |

## Verification
Every output of the block depends combinationally on the inputs of the same cycle. The bench therefore drives the isolated-block vectors just after a falling edge and samples them 1 ns later, within the same cycle. In the pipeline model that wraps the block, a decision made in cycle N is seen in the model's PC, fetch/decode and execute-stage registers after the rising edge that ends cycle N. The bench samples those registers at each following falling edge. It then compares the whole recorded sequence, with a bubble or flush expected in exactly one slot.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   // next-fetch source chosen in decode
   typedef enum logic {
      PC_SEQ    = 1'b0,
      PC_BRANCH = 1'b1
   } pc_src_e;

   localparam int unsigned DEF_XLEN        = 32;
   localparam int unsigned DEF_RAW         = 5;
   localparam int unsigned DEF_IMM_W       = 16;
   localparam int unsigned DEF_CTRL_W      = 8;
   localparam int unsigned DEF_INSTR_BYTES = 4;

endpackage

// File: rtl/hzd_load_use_detect.sv
module hzd_load_use_detect #(
   parameter int unsigned RAW = 5
) (
   input  logic           ld_valid,
   input  logic [RAW-1:0] ld_dst,
   input  logic [RAW-1:0] use_src0,
   input  logic [RAW-1:0] use_src1,
   output logic           stall
);

   logic [1:0] hit;

   assign hit[0] = (ld_dst == use_src0);
   assign hit[1] = (ld_dst == use_src1);
   assign stall  = ld_valid & (|hit);

endmodule

// File: rtl/hzd_branch_resolve.sv
module hzd_branch_resolve #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned IMM_W       = 16,
   parameter int unsigned INSTR_BYTES = 4,
   parameter int unsigned CMP_STYLE   = 0
) (
   input  logic             is_branch,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [IMM_W-1:0] offset,
   output logic             take,
   output logic [XLEN-1:0]  target
);

   localparam int unsigned SHIFT = $clog2(INSTR_BYTES);
   localparam int unsigned EXT_W = XLEN - IMM_W;

   if (INSTR_BYTES == 0 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("hzd_branch_resolve: INSTR_BYTES must be a power of two");
   end
   if (IMM_W + SHIFT > XLEN) begin : g_bad_imm
      $error("hzd_branch_resolve: IMM_W plus scaling exceeds XLEN");
   end
   if (CMP_STYLE > 1) begin : g_bad_cmp
      $error("hzd_branch_resolve: CMP_STYLE must be 0 or 1");
   end

   logic [XLEN-1:0] off_ext;
   logic [XLEN-1:0] off_scaled;
   logic            same;

   // sign extension: only needed when the offset is narrower than the address
   if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{offset[IMM_W-1]}}, offset};
   end else begin : g_nosext
      assign off_ext = offset[XLEN-1:0];
   end

   assign off_scaled = off_ext << SHIFT;
   assign target     = seq_pc + off_scaled;

   // equality comparator variant
   if (CMP_STYLE == 0) begin : g_cmp_eq
      assign same = (opnd_a == opnd_b);
   end else begin : g_cmp_xor
      logic [XLEN-1:0] diff;
      for (genvar i = 0; i < XLEN; i++) begin : g_bit
         assign diff[i] = opnd_a[i] ^ opnd_b[i];
      end
      assign same = ~|diff;
   end

   assign take = is_branch & same;

endmodule

// File: rtl/hzd_ctrl_squash.sv
module hzd_ctrl_squash #(
   parameter int unsigned CTRL_W = 8
) (
   input  logic              kill,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic [CTRL_W-1:0] ctrl_out
);

   if (CTRL_W == 0) begin : g_bad_w
      $error("hzd_ctrl_squash: CTRL_W must be nonzero");
   end

   for (genvar i = 0; i < CTRL_W; i++) begin : g_gate
      assign ctrl_out[i] = ctrl_in[i] & ~kill;
   end

endmodule

// File: rtl/hzd_decode_ctrl.sv
module hzd_decode_ctrl
   import hzd_pkg::*;
#(
   parameter int unsigned XLEN        = DEF_XLEN,
   parameter int unsigned RAW         = DEF_RAW,
   parameter int unsigned IMM_W       = DEF_IMM_W,
   parameter int unsigned CTRL_W      = DEF_CTRL_W,
   parameter int unsigned INSTR_BYTES = DEF_INSTR_BYTES,
   parameter int unsigned CMP_STYLE   = 0
) (
   input  logic              idex_mem_read,
   input  logic [RAW-1:0]    idex_rt,
   input  logic [RAW-1:0]    ifid_rs,
   input  logic [RAW-1:0]    ifid_rt,
   input  logic              ifid_is_branch,
   input  logic [XLEN-1:0]   ifid_pc_plus4,
   input  logic [IMM_W-1:0]  ifid_imm,
   input  logic [XLEN-1:0]   rd_data_a,
   input  logic [XLEN-1:0]   rd_data_b,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic              pc_write_en,
   output logic              ifid_write_en,
   output logic              ctrl_zero_sel,
   output logic [CTRL_W-1:0] ctrl_out,
   output logic              ifid_flush,
   output logic              pc_redirect,
   output logic [XLEN-1:0]   branch_target
);

   if (RAW == 0) begin : g_bad_raw
      $error("hzd_decode_ctrl: RAW must be nonzero");
   end

   logic    lu_stall;
   logic    br_take;
   pc_src_e pc_src;

   hzd_load_use_detect #(
      .RAW (RAW)
   ) u_lu (
      .ld_valid (idex_mem_read),
      .ld_dst   (idex_rt),
      .use_src0 (ifid_rs),
      .use_src1 (ifid_rt),
      .stall    (lu_stall)
   );

   hzd_branch_resolve #(
      .XLEN        (XLEN),
      .IMM_W       (IMM_W),
      .INSTR_BYTES (INSTR_BYTES),
      .CMP_STYLE   (CMP_STYLE)
   ) u_br (
      .is_branch (ifid_is_branch),
      .opnd_a    (rd_data_a),
      .opnd_b    (rd_data_b),
      .seq_pc    (ifid_pc_plus4),
      .offset    (ifid_imm),
      .take      (br_take),
      .target    (branch_target)
   );

   hzd_ctrl_squash #(
      .CTRL_W (CTRL_W)
   ) u_sq (
      .kill     (lu_stall),
      .ctrl_in  (ctrl_in),
      .ctrl_out (ctrl_out)
   );

   // stall wins: a held branch is re-evaluated once the load has moved on
   always_comb begin
      pc_src = PC_SEQ;
      if (!lu_stall && br_take) begin
         pc_src = PC_BRANCH;
      end
   end

   assign pc_write_en   = ~lu_stall;
   assign ifid_write_en = ~lu_stall;
   assign ctrl_zero_sel = lu_stall;
   assign pc_redirect   = (pc_src == PC_BRANCH);
   assign ifid_flush    = (pc_src == PC_BRANCH);

endmodule

// File: rtl/hzd_decode_ctrl_chk.sv
module hzd_decode_ctrl_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned RAW    = 5,
   parameter int unsigned CTRL_W = 8
) (
   input logic              idex_mem_read,
   input logic [RAW-1:0]    idex_rt,
   input logic [RAW-1:0]    ifid_rs,
   input logic [RAW-1:0]    ifid_rt,
   input logic              ifid_is_branch,
   input logic [XLEN-1:0]   rd_data_a,
   input logic [XLEN-1:0]   rd_data_b,
   input logic [CTRL_W-1:0] ctrl_in,
   input logic              pc_write_en,
   input logic              ifid_write_en,
   input logic              ctrl_zero_sel,
   input logic [CTRL_W-1:0] ctrl_out,
   input logic              ifid_flush,
   input logic              pc_redirect
);

   always_comb begin
      // R1
      load_use_hold_chk: assert (!(idex_mem_read && (idex_rt == ifid_rs || idex_rt == ifid_rt)) || !pc_write_en)
         else $error("load-use hazard did not freeze the PC");
      // R3
      pc_ifid_same_chk: assert (pc_write_en == ifid_write_en)
         else $error("PC and IF/ID enables disagree");
      // R2
      bubble_zero_chk: assert (!ctrl_zero_sel || ctrl_out == '0)
         else $error("bubble carries nonzero control");
      // R2
      pass_through_chk: assert (ctrl_zero_sel || ctrl_out == ctrl_in)
         else $error("control altered without a stall");
      // R5
      flush_with_redirect_chk: assert (ifid_flush == pc_redirect)
         else $error("flush and redirect disagree");
      // R7
      no_redirect_in_stall_chk: assert (!(pc_redirect && !pc_write_en))
         else $error("redirect issued during a stall");
      // R6
      redirect_needs_equal_chk: assert (!pc_redirect || (ifid_is_branch && rd_data_a == rd_data_b))
         else $error("redirect without an equal-operand branch");
   end

endmodule

bind hzd_decode_ctrl hzd_decode_ctrl_chk #(
   .XLEN   (XLEN),
   .RAW    (RAW),
   .CTRL_W (CTRL_W)
) i_hzd_decode_ctrl_chk (
   .idex_mem_read  (idex_mem_read),
   .idex_rt        (idex_rt),
   .ifid_rs        (ifid_rs),
   .ifid_rt        (ifid_rt),
   .ifid_is_branch (ifid_is_branch),
   .rd_data_a      (rd_data_a),
   .rd_data_b      (rd_data_b),
   .ctrl_in        (ctrl_in),
   .pc_write_en    (pc_write_en),
   .ifid_write_en  (ifid_write_en),
   .ctrl_zero_sel  (ctrl_zero_sel),
   .ctrl_out       (ctrl_out),
   .ifid_flush     (ifid_flush),
   .pc_redirect    (pc_redirect)
);

// File: tb/test_hzd_decode_ctrl.sv
`timescale 1ns/1ps
module test_hzd_decode_ctrl;

   localparam int XLEN = 32, RAW = 5, IMM_W = 16, CTRL_W = 8;
   localparam logic [5:0] OP_ALU = 6'h00, OP_LOAD = 6'h23, OP_BEQ = 6'h04;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   // direct stimulus
   logic              sys_mode = 1'b0;
   logic              d_mr = 1'b0, d_br = 1'b0;
   logic [RAW-1:0]    d_irt = '0, d_rs = '0, d_rt = '0;
   logic [XLEN-1:0]   d_pc4 = '0, d_a = '0, d_b = '0;
   logic [IMM_W-1:0]  d_imm = '0;
   logic [CTRL_W-1:0] d_ctrl = '0;

   // pipeline model state
   logic [31:0]       prog [0:15];
   logic              m_rst = 1'b1;
   logic [31:0]       m_pc, m_ifid, m_ifid_pc4;
   logic [CTRL_W-1:0] m_idex_ctrl;
   logic [RAW-1:0]    m_idex_rt;

   function automatic logic [31:0] regval(input logic [4:0] i);
      return (i == 5'd3 || i == 5'd4) ? 32'h55 : 32'h1000 + 32'(i);
   endfunction

   // control word: {valid, load, tag}
   function automatic logic [7:0] ctrl_of(input logic [31:0] w);
      return (w == 32'h0) ? 8'h00 : {1'b1, w[31:26] == OP_LOAD, w[5:0]};
   endfunction

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   // block inputs
   logic              idex_mem_read, ifid_is_branch;
   logic [RAW-1:0]    idex_rt, ifid_rs, ifid_rt;
   logic [XLEN-1:0]   ifid_pc_plus4, rd_data_a, rd_data_b;
   logic [IMM_W-1:0]  ifid_imm;
   logic [CTRL_W-1:0] ctrl_in;
   // block outputs
   logic              pc_write_en, ifid_write_en, ctrl_zero_sel, ifid_flush, pc_redirect;
   logic [CTRL_W-1:0] ctrl_out;
   logic [XLEN-1:0]   branch_target;

   assign idex_mem_read  = sys_mode ? m_idex_ctrl[6] : d_mr;
   assign idex_rt        = sys_mode ? m_idex_rt : d_irt;
   assign ifid_rs        = sys_mode ? m_ifid[25:21] : d_rs;
   assign ifid_rt        = sys_mode ? m_ifid[20:16] : d_rt;
   assign ifid_is_branch = sys_mode ? (m_ifid[31:26] == OP_BEQ && m_ifid != 0) : d_br;
   assign ifid_pc_plus4  = sys_mode ? m_ifid_pc4 : d_pc4;
   assign ifid_imm       = sys_mode ? m_ifid[15:0] : d_imm;
   assign rd_data_a      = sys_mode ? regval(m_ifid[25:21]) : d_a;
   assign rd_data_b      = sys_mode ? regval(m_ifid[20:16]) : d_b;
   assign ctrl_in        = sys_mode ? ctrl_of(m_ifid) : d_ctrl;

   hzd_decode_ctrl i_hzd_decode_ctrl (
      .idex_mem_read  (idex_mem_read),
      .idex_rt        (idex_rt),
      .ifid_rs        (ifid_rs),
      .ifid_rt        (ifid_rt),
      .ifid_is_branch (ifid_is_branch),
      .ifid_pc_plus4  (ifid_pc_plus4),
      .ifid_imm       (ifid_imm),
      .rd_data_a      (rd_data_a),
      .rd_data_b      (rd_data_b),
      .ctrl_in        (ctrl_in),
      .pc_write_en    (pc_write_en),
      .ifid_write_en  (ifid_write_en),
      .ctrl_zero_sel  (ctrl_zero_sel),
      .ctrl_out       (ctrl_out),
      .ifid_flush     (ifid_flush),
      .pc_redirect    (pc_redirect),
      .branch_target  (branch_target)
   );

   // cycle-accurate PC / IF/ID / ID/EX model around the block
   always @(posedge clk) begin
      if (m_rst) begin
         m_pc <= 32'h0; m_ifid <= 32'h0; m_ifid_pc4 <= 32'h0;
         m_idex_ctrl <= '0; m_idex_rt <= '0;
      end else begin
         if (pc_write_en) m_pc <= pc_redirect ? branch_target : m_pc + 32'd4;
         if (ifid_flush) begin
            m_ifid <= 32'h0; m_ifid_pc4 <= 32'h0;
         end else if (ifid_write_en) begin
            m_ifid <= prog[m_pc[5:2]]; m_ifid_pc4 <= m_pc + 32'd4;
         end
         m_idex_ctrl <= ctrl_out;
         m_idex_rt   <= m_ifid[20:16];
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_stall(input logic mr, input logic [4:0] lrt,
                                      input logic [4:0] rs, input logic [4:0] rt);
      return mr && (lrt == rs || lrt == rt);
   endfunction

   function automatic logic [31:0] exp_target(input logic [31:0] pc4, input logic [15:0] imm);
      return pc4 + ({{16{imm[15]}}, imm} << 2);
   endfunction

   task automatic check_vector();
      logic s, tk;
      #1;
      s  = exp_stall(d_mr, d_irt, d_rs, d_rt);
      tk = d_br && (d_a == d_b) && !s;
      chk("R1", "stall(pc_write_en low)", {63'b0, ~pc_write_en}, {63'b0, s});
      chk("R2", "ctrl_out", 64'(ctrl_out), s ? 64'h0 : 64'(d_ctrl));
      chk("R2", "ctrl_zero_sel", {63'b0, ctrl_zero_sel}, {63'b0, s});
      chk("R3", "ifid_write_en", {63'b0, ifid_write_en}, {63'b0, ~s});
      chk("R4", "branch_target", 64'(branch_target), 64'(exp_target(d_pc4, d_imm)));
      chk(tk ? "R5" : (s ? "R7" : "R6"), "pc_redirect", {63'b0, pc_redirect}, {63'b0, tk});
      chk(tk ? "R5" : (s ? "R7" : "R6"), "ifid_flush", {63'b0, ifid_flush}, {63'b0, tk});
   endtask

   logic [7:0]  h_ctrl [0:5];
   logic [31:0] h_pc   [0:5];
   logic [31:0] h_ifid [0:5];
   logic        h_redir[0:5];
   logic        h_wen  [0:5];

   task automatic run_prog();
      sys_mode = 1'b1;
      @(negedge clk); m_rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R3", "reset pc_write_en", {63'b0, pc_write_en}, 64'h1);
      chk("R6", "reset pc_redirect", {63'b0, pc_redirect}, 64'h0);
      m_rst = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); @(negedge clk);
         h_ctrl[i] = m_idex_ctrl; h_pc[i] = m_pc; h_ifid[i] = m_ifid;
         h_redir[i] = pc_redirect; h_wen[i] = pc_write_en;
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 16; i++) prog[i] = 32'h0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_2024));
      // constrained random vectors on the isolated block
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         d_mr   = ($urandom % 2) == 0;
         d_irt  = 5'($urandom % 4);
         d_rs   = 5'($urandom % 4);
         d_rt   = 5'($urandom % 4);
         d_br   = ($urandom % 2) == 0;
         d_a    = $urandom;
         d_b    = (($urandom % 2) == 0) ? d_a : $urandom;
         d_pc4  = $urandom & 32'hFFFF_FFFC;
         d_imm  = 16'($urandom);
         d_ctrl = 8'($urandom);
         check_vector();
      end
      // directed corners: R4 negative offset, wrap, most negative offset
      @(negedge clk); d_mr = 0; d_br = 1; d_a = 7; d_b = 7; d_pc4 = 32'h4; d_imm = 16'hFFFF; d_ctrl = 8'hA5;
      check_vector();
      chk("R4", "target -1 word", 64'(branch_target), 64'h0);
      @(negedge clk); d_pc4 = 32'hFFFF_FFFC; d_imm = 16'h0001; check_vector();
      chk("R4", "target wrap", 64'(branch_target), 64'h0);
      @(negedge clk); d_pc4 = 32'h0004_0000; d_imm = 16'h8000; check_vector();
      chk("R4", "target min offset", 64'(branch_target), 64'h0002_0000);
      // R1: register 0 dependence still stalls
      @(negedge clk); d_mr = 1; d_irt = 0; d_rs = 0; d_rt = 9; check_vector();
      chk("R1", "r0 dependence stalls", {63'b0, pc_write_en}, 64'h0);
      // R7: taken branch under stall
      @(negedge clk); d_mr = 1; d_irt = 4; d_rs = 1; d_rt = 4; d_br = 1; d_a = 3; d_b = 3; check_vector();
      chk("R7", "no flush in stall", {63'b0, ifid_flush}, 64'h0);

      // R8: load then dependent instruction (via rs)
      clear_prog();
      prog[0] = mk(OP_LOAD, 5'd1, 5'd5, 16'd1);
      prog[1] = mk(OP_ALU,  5'd5, 5'd2, 16'd2);
      prog[2] = mk(OP_ALU,  5'd1, 5'd2, 16'd3);
      prog[3] = mk(OP_ALU,  5'd1, 5'd2, 16'd4);
      run_prog();
      chk("R8", "idex seq0", 64'(h_ctrl[0]), 64'h00);
      chk("R8", "idex seq1 load", 64'(h_ctrl[1]), 64'hC1);
      chk("R8", "idex seq2 bubble", 64'(h_ctrl[2]), 64'h00);
      chk("R8", "idex seq3 dependent", 64'(h_ctrl[3]), 64'h82);
      chk("R8", "idex seq4", 64'(h_ctrl[4]), 64'h83);
      chk("R8", "pc held", 64'(h_pc[2]), 64'h8);
      chk("R8", "ifid held", 64'(h_ifid[2]), 64'(prog[1]));
      // R8: dependence via rt
      prog[1] = mk(OP_ALU, 5'd2, 5'd5, 16'd2);
      run_prog();
      chk("R8", "rt dep bubble", 64'(h_ctrl[2]), 64'h00);
      chk("R8", "rt dep next", 64'(h_ctrl[3]), 64'h82);
      // R8: independent instruction, no bubble
      prog[1] = mk(OP_ALU, 5'd6, 5'd7, 16'd2);
      run_prog();
      chk("R8", "indep seq2", 64'(h_ctrl[2]), 64'h82);
      chk("R8", "indep seq3", 64'(h_ctrl[3]), 64'h83);

      // R9: taken branch flushes exactly one slot
      clear_prog();
      prog[0] = mk(OP_ALU, 5'd1, 5'd2, 16'd1);
      prog[1] = mk(OP_BEQ, 5'd3, 5'd4, 16'd3);
      prog[2] = mk(OP_ALU, 5'd1, 5'd2, 16'd10);
      prog[5] = mk(OP_ALU, 5'd1, 5'd2, 16'd11);
      prog[6] = mk(OP_ALU, 5'd1, 5'd2, 16'd12);
      run_prog();
      chk("R9", "pc at target", 64'(h_pc[2]), 64'd20);
      chk("R9", "ifid zeroed", 64'(h_ifid[2]), 64'h0);
      chk("R9", "idex branch", 64'(h_ctrl[2]), 64'h83);
      chk("R9", "idex squashed", 64'(h_ctrl[3]), 64'h00);
      chk("R9", "idex target instr", 64'(h_ctrl[4]), 64'h8B);
      chk("R9", "idex after target", 64'(h_ctrl[5]), 64'h8C);
      // R6: not-taken branch keeps sequential fetch
      prog[1] = mk(OP_BEQ, 5'd3, 5'd5, 16'd3);
      prog[3] = mk(OP_ALU, 5'd1, 5'd2, 16'd13);
      run_prog();
      chk("R6", "no redirect", {63'b0, h_redir[1]}, 64'h0);
      chk("R6", "seq pc", 64'(h_pc[2]), 64'd12);
      chk("R6", "wrong path runs", 64'(h_ctrl[3]), 64'h8A);

      // R7: branch depending on a load waits, then resolves
      clear_prog();
      prog[0] = mk(OP_LOAD, 5'd1, 5'd3, 16'd1);
      prog[1] = mk(OP_BEQ,  5'd3, 5'd4, 16'd3);
      prog[2] = mk(OP_ALU,  5'd1, 5'd2, 16'd10);
      prog[5] = mk(OP_ALU,  5'd1, 5'd2, 16'd11);
      run_prog();
      chk("R7", "stalled no redirect", {63'b0, h_redir[1]}, 64'h0);
      chk("R7", "stalled pc frozen", {63'b0, h_wen[1]}, 64'h0);
      chk("R7", "resolved after stall", {63'b0, h_redir[2]}, 64'h1);
      chk("R7", "idex bubble", 64'(h_ctrl[2]), 64'h00);
      chk("R7", "pc at target", 64'(h_pc[3]), 64'd20);
      chk("R7", "idex branch", 64'(h_ctrl[3]), 64'h83);
      chk("R7", "idex target instr", 64'(h_ctrl[5]), 64'h8B);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule